// File: doc/BRIEF.md
# Receive-Ring Free-Buffer Pause Trigger

This block watches a set of receive descriptor rings and asks the transmit side for a PAUSE frame when any ring is about to run out of free buffers. Each ring has three pieces of state. The first is a configuration word that holds the ring size and a free-buffer threshold. The second is a last-free index that software writes each time it returns a buffer. The third is a current index that steps forward on every consume pulse from the receive side. A ring's free count is the distance from the current index forward to the last-free index, taken modulo the ring size.

Software programs the thresholds and the pause time with the global lossless enable clear, and sets the enable afterwards. When transmit flow control is switched on (`txFlowEn` rises), the block reloads every last-free index with the descriptor just behind the ring's current position. This marks each ring as entirely free. While the global enable and `txFlowEn` are both high and some in-use ring has fewer free buffers than its threshold, the block holds a request to the frame transmitter. The programmed pause quanta are presented beside the request. After an acknowledge the block waits half the pause time before it may request again.

Top module: `rx_pause_trigger`

## Requirements
- R1: After reset, `pauseReq` is 0, the control word reads 0, and the pause time reads 4. Every ring configuration word reads 0x1000_0000, which is threshold 16 and size 0. Every last-free index and current index is 0.
- R2: The configuration word of ring r sits at byte offset 0x20+4r. The threshold occupies bits 31:24 and the ring size occupies bits 8:0. All other bits are dropped on write and read as zero.
- R3: The last-free index of ring r sits at offset 0x40+8r and keeps only bits 7:0 of a write. A write to a reserved word at 0x44+8r changes nothing, and a read of it returns 0.
- R4: A consume pulse with `consumeRing`=r advances ring r's current index by one, wrapping to 0 at the ring size. The free count is (lastFree − current) mod size.
- R5: A ring counts as short when its size is non-zero and its free count is below its threshold. `pauseReq` rises on the first clock edge after the edge at which some ring becomes short, provided both enables are high.
- R6: While control bit 14 at offset 0x00 is 0, or while `txFlowEn` is 0, `pauseReq` stays 0. Clearing either enable drops a pending request one edge later.
- R7: On the clock edge where `txFlowEn` is sampled 1 after being 0, each ring's last-free index becomes (current + size − 1) mod size. For a ring of size 0 the index becomes 0.
- R8: `pauseReq` stays high until it is acknowledged. If no ring is short any longer before the acknowledge, the request is withdrawn one edge later.
- R9: An edge with `pauseReq` and `pauseAck` both high drops `pauseReq`. A new request can rise no earlier than H+1 edges after that edge, where H is the pause time shifted right by one. It rises then only if a ring is still short.
- R10: The pause time register at offset 0x04 keeps bits 15:0 of a write and drives `pauseTime` continuously.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 8 | Register byte offset for reads and writes |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for `regAddr`, combinational |
| consumeValid | input | 1 | Receive side filled one descriptor |
| consumeRing | input | 3 | Ring that the consume pulse refers to |
| txFlowEn | input | 1 | Transmit flow control enable from the MAC configuration |
| pauseReq | output | 1 | PAUSE frame request to the transmitter |
| pauseAck | input | 1 | Transmitter accepted the request |
| pauseTime | output | 16 | Pause quanta for the frame |

## Verification
Register reads are combinational, so the bench compares `regRdData` in the same cycle it sets `regAddr`. A write, a consume pulse or a `txFlowEn` change lands on one edge. Its effect on stored indices can be read straight after that edge, and its effect on `pauseReq` appears one edge later. The bench therefore samples the request once just after the causing edge, expecting the old value, and once after the following edge, expecting the new one. For the re-arm window the pause time is 4 (H = 2). The request is checked low after the first and second edges that follow the acknowledge edge and high after the third.

// File: rtl/rx_pause_pkg.sv
package rx_pause_pkg;
  // strobes the control path hands to the datapath
  typedef struct packed {
    logic loadLastFree;   // reload every last-free index behind the current one
  } ctrlStrobes_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_REQ   = 2'd1,
    ST_REARM = 2'd2
  } trigState_t;
endpackage

// File: rtl/rx_pause_ring.sv
// Per-ring occupancy: current index, free count, short flag and refill value.
module rx_pause_ring #(
  parameter int IDX_W = 8,
  parameter int SIZE_W = IDX_W + 1,
  parameter int THR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [SIZE_W-1:0] ringSize,
  input  logic [THR_W-1:0]  threshold,
  input  logic [IDX_W-1:0]  lastFree,
  input  logic              consume,
  output logic              isShort,
  output logic [IDX_W-1:0]  refillIdx
);
  logic [IDX_W-1:0]  curIdx;
  logic [SIZE_W-1:0] curWide;
  logic [SIZE_W-1:0] lastWide;
  logic [SIZE_W-1:0] nextWide;
  logic [SIZE_W-1:0] freeCount;
  logic [SIZE_W-1:0] behindWide;
  logic              sizeZero;

  assign sizeZero = (ringSize == '0);
  assign curWide  = SIZE_W'(curIdx);
  assign lastWide = SIZE_W'(lastFree);
  assign nextWide = curWide + SIZE_W'(1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curIdx <= '0;
    end else if (consume && !sizeZero) begin
      if (nextWide >= ringSize) curIdx <= '0;
      else                      curIdx <= nextWide[IDX_W-1:0];
    end
  end

  always_comb begin
    if (lastWide >= curWide) freeCount = lastWide - curWide;
    else                     freeCount = lastWide + ringSize - curWide;
  end

  assign isShort = !sizeZero && (freeCount < SIZE_W'(threshold));

  always_comb begin
    if (sizeZero)          behindWide = '0;
    else if (curIdx == '0) behindWide = ringSize - SIZE_W'(1);
    else                   behindWide = curWide - SIZE_W'(1);
  end
  assign refillIdx = behindWide[IDX_W-1:0];
endmodule

// File: rtl/rx_pause_datapath.sv
// Register file, per-ring occupancy and the combined short flag.
module rx_pause_datapath
  import rx_pause_pkg::*;
#(
  parameter int RINGS = 8,
  parameter int ADDR_W = 8,
  parameter int IDX_W = 8,
  parameter int THR_W = 8,
  parameter int PT_W = 16,
  parameter int DEF_THR = 16,
  parameter int DEF_PTIME = 4,
  parameter int EN_BIT = 14
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     regWrEn,
  input  logic [ADDR_W-1:0]        regAddr,
  input  logic [31:0]              regWrData,
  output logic [31:0]              regRdData,
  input  logic                     consumeValid,
  input  logic [$clog2(RINGS)-1:0] consumeRing,
  input  ctrlStrobes_t             strobes,
  output logic                     lfcShort,
  output logic [PT_W-1:0]          pauseTime
);
  localparam int SIZE_W = IDX_W + 1;
  localparam int PAD_W = 32 - THR_W - SIZE_W;
  localparam int PARAM_BASE = 32;
  localparam int PTR_BASE = PARAM_BASE + 4 * RINGS;
  localparam logic [ADDR_W-1:0] CTRL_OFS = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] PTIME_OFS = ADDR_W'(4);

  logic                    lfcEn;
  logic [PT_W-1:0]         ptimeReg;
  logic [THR_W-1:0]        thrReg   [RINGS];
  logic [SIZE_W-1:0]       sizeReg  [RINGS];
  logic [IDX_W-1:0]        lastFree [RINGS];
  logic [IDX_W-1:0]        refill   [RINGS];
  logic [RINGS-1:0]        shortVec;
  logic [RINGS-1:0]        paramHit;
  logic [RINGS-1:0]        ptrHit;
  logic [31:0]             ringRd   [RINGS];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lfcEn    <= 1'b0;
      ptimeReg <= PT_W'(DEF_PTIME);
    end else if (regWrEn) begin
      if (regAddr == CTRL_OFS)  lfcEn    <= regWrData[EN_BIT];
      if (regAddr == PTIME_OFS) ptimeReg <= regWrData[PT_W-1:0];
    end
  end

  for (genvar r = 0; r < RINGS; r++) begin : g_ring
    localparam logic [ADDR_W-1:0] PARAM_OFS = ADDR_W'(PARAM_BASE + 4 * r);
    localparam logic [ADDR_W-1:0] PTR_OFS = ADDR_W'(PTR_BASE + 8 * r);

    assign paramHit[r] = (regAddr == PARAM_OFS);
    assign ptrHit[r]   = (regAddr == PTR_OFS);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        thrReg[r]  <= THR_W'(DEF_THR);
        sizeReg[r] <= '0;
      end else if (regWrEn && paramHit[r]) begin
        thrReg[r]  <= regWrData[31:32-THR_W];
        sizeReg[r] <= regWrData[SIZE_W-1:0];
      end
    end

    // a software write to this ring's index wins over the flow-on reload
    always_ff @(posedge clk) begin
      if (!rstN)                         lastFree[r] <= '0;
      else if (regWrEn && ptrHit[r])     lastFree[r] <= regWrData[IDX_W-1:0];
      else if (strobes.loadLastFree)     lastFree[r] <= refill[r];
    end

    rx_pause_ring #(
      .IDX_W (IDX_W),
      .SIZE_W(SIZE_W),
      .THR_W (THR_W)
    ) u_ring (
      .clk      (clk),
      .rstN     (rstN),
      .ringSize (sizeReg[r]),
      .threshold(thrReg[r]),
      .lastFree (lastFree[r]),
      .consume  (consumeValid && (consumeRing == ($clog2(RINGS))'(r))),
      .isShort  (shortVec[r]),
      .refillIdx(refill[r])
    );

    always_comb begin
      ringRd[r] = '0;
      if (paramHit[r]) ringRd[r] = {thrReg[r], {PAD_W{1'b0}}, sizeReg[r]};
      if (ptrHit[r])   ringRd[r] = 32'(lastFree[r]);
    end
  end

  always_comb begin
    regRdData = '0;
    if (regAddr == CTRL_OFS)  regRdData[EN_BIT] = lfcEn;
    if (regAddr == PTIME_OFS) regRdData = 32'(ptimeReg);
    for (int r = 0; r < RINGS; r++) regRdData = regRdData | ringRd[r];
  end

  assign lfcShort  = lfcEn && (|shortVec);
  assign pauseTime = ptimeReg;
endmodule

// File: rtl/rx_pause_control.sv
// Flow-enable edge detection and the request / acknowledge / re-arm sequence.
module rx_pause_control
  import rx_pause_pkg::*;
#(
  parameter int PT_W = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            txFlowEn,
  input  logic            lfcShort,
  input  logic            pauseAck,
  input  logic [PT_W-1:0] pauseTime,
  output ctrlStrobes_t    strobes,
  output logic            pauseReq
);
  trigState_t      state;
  logic            flowQ;
  logic            want;
  logic [PT_W-1:0] halfTime;
  logic [PT_W-1:0] rearmCnt;

  assign want     = lfcShort && txFlowEn;
  assign halfTime = pauseTime >> 1;

  always_ff @(posedge clk) begin
    if (!rstN) flowQ <= 1'b0;
    else       flowQ <= txFlowEn;
  end
  assign strobes.loadLastFree = txFlowEn && !flowQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      rearmCnt <= '0;
    end else begin
      case (state)
        ST_IDLE: if (want) state <= ST_REQ;
        ST_REQ: begin
          if (pauseAck) begin
            rearmCnt <= halfTime;
            state    <= (halfTime == '0) ? ST_IDLE : ST_REARM;
          end else if (!want) begin
            state <= ST_IDLE;
          end
        end
        ST_REARM: begin
          if (rearmCnt <= PT_W'(1)) state <= ST_IDLE;
          else                      rearmCnt <= rearmCnt - PT_W'(1);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign pauseReq = (state == ST_REQ);
endmodule

// File: rtl/rx_pause_trigger.sv
module rx_pause_trigger
  import rx_pause_pkg::*;
#(
  parameter int RINGS = 8,
  parameter int ADDR_W = 8,
  parameter int IDX_W = 8,
  parameter int THR_W = 8,
  parameter int PT_W = 16,
  parameter int DEF_THR = 16,
  parameter int DEF_PTIME = 4,
  parameter int EN_BIT = 14,
  localparam int RING_W = $clog2(RINGS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  logic              consumeValid,
  input  logic [RING_W-1:0] consumeRing,
  input  logic              txFlowEn,
  output logic              pauseReq,
  input  logic              pauseAck,
  output logic [PT_W-1:0]   pauseTime
);
  ctrlStrobes_t strobes;
  logic         lfcShort;

  rx_pause_datapath #(
    .RINGS    (RINGS),
    .ADDR_W   (ADDR_W),
    .IDX_W    (IDX_W),
    .THR_W    (THR_W),
    .PT_W     (PT_W),
    .DEF_THR  (DEF_THR),
    .DEF_PTIME(DEF_PTIME),
    .EN_BIT   (EN_BIT)
  ) u_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .regWrEn     (regWrEn),
    .regAddr     (regAddr),
    .regWrData   (regWrData),
    .regRdData   (regRdData),
    .consumeValid(consumeValid),
    .consumeRing (consumeRing),
    .strobes     (strobes),
    .lfcShort    (lfcShort),
    .pauseTime   (pauseTime)
  );

  rx_pause_control #(
    .PT_W(PT_W)
  ) u_control (
    .clk      (clk),
    .rstN     (rstN),
    .txFlowEn (txFlowEn),
    .lfcShort (lfcShort),
    .pauseAck (pauseAck),
    .pauseTime(pauseTime),
    .strobes  (strobes),
    .pauseReq (pauseReq)
  );
endmodule

// File: rtl/rx_pause_checker.sv
module rx_pause_checker #(
  parameter int PT_W = 16
) (
  input logic            clk,
  input logic            rstN,
  input logic            regWrEn,
  input logic            txFlowEn,
  input logic            lfcShort,
  input logic            pauseReq,
  input logic            pauseAck,
  input logic [PT_W-1:0] pauseTime
);
  AST_REQ_NEEDS_FLOW: assert property (@(posedge clk) disable iff (!rstN)
    pauseReq |-> $past(txFlowEn)); // R6

  AST_RISE_NEEDS_SHORT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pauseReq) |-> $past(lfcShort && txFlowEn)); // R5

  AST_HOLD_UNTIL_ACK: assert property (@(posedge clk) disable iff (!rstN)
    (pauseReq && !pauseAck && lfcShort && txFlowEn) |=> pauseReq); // R8

  AST_ACK_DROPS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    (pauseReq && pauseAck) |=> !pauseReq); // R9

  AST_PTIME_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    !regWrEn |=> $stable(pauseTime)); // R10
endmodule

bind rx_pause_trigger rx_pause_checker #(.PT_W(PT_W)) u_checker (
  .clk      (clk),
  .rstN     (rstN),
  .regWrEn  (regWrEn),
  .txFlowEn (txFlowEn),
  .lfcShort (lfcShort),
  .pauseReq (pauseReq),
  .pauseAck (pauseAck),
  .pauseTime(pauseTime)
);

// File: tb/test_rx_pause_trigger.sv
module test_rx_pause_trigger;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [7:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        consumeValid = 1'b0;
  logic [2:0]  consumeRing = '0;
  logic        txFlowEn = 1'b0;
  logic        pauseReq;
  logic        pauseAck = 1'b0;
  logic [15:0] pauseTime;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  typedef struct {
    int          kind;   // 0 read data, 1 request, 2 pause time port
    logic [31:0] exp;
    string       tag;
  } expItem_t;

  expItem_t expQ[$];
  event     sampleEv;

  always #5 clk = ~clk;

  rx_pause_trigger i_rx_pause_trigger (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .consumeValid(consumeValid),
    .consumeRing(consumeRing), .txFlowEn(txFlowEn), .pauseReq(pauseReq),
    .pauseAck(pauseAck), .pauseTime(pauseTime)
  );

  // monitor: pops each expected item and compares it with the design output
  initial begin
    forever begin
      @(sampleEv);
      #2;
      if (expQ.size() != 0) begin
        expItem_t it;
        logic [31:0] act;
        it = expQ.pop_front();
        case (it.kind)
          0:       act = regRdData;
          1:       act = {31'b0, pauseReq};
          default: act = {16'b0, pauseTime};
        endcase
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s actual=0x%08h expected=0x%08h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic push(input int kind, input logic [31:0] exp, input string tag);
    expItem_t it;
    it.kind = kind; it.exp = exp; it.tag = tag;
    expQ.push_back(it);
    -> sampleEv;
    #3;
  endtask

  task automatic expRd(input logic [7:0] addr, input logic [31:0] exp, input string tag);
    regAddr = addr;
    push(0, exp, tag);
  endtask

  task automatic expReq(input logic exp, input string tag);
    push(1, {31'b0, exp}, tag);
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wrReg(input logic [7:0] addr, input logic [31:0] data);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = addr; regWrData = data;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic consume(input logic [2:0] ring, input int n);
    @(negedge clk);
    consumeValid = 1'b1; consumeRing = ring;
    tick(n);
    consumeValid = 1'b0;
  endtask

  task automatic setFlow(input logic v);
    @(negedge clk);
    txFlowEn = v;
    @(negedge clk);
  endtask

  task automatic ack();
    @(negedge clk);
    pauseAck = 1'b1;
    @(negedge clk);
    pauseAck = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(3);
    rstN = 1'b1;
    tick(1);
    // reset state
    expReq(1'b0, "R1 request after reset");
    expRd(8'h00, 32'h0, "R1 control after reset");
    expRd(8'h04, 32'h4, "R1 pause time after reset");
    expRd(8'h3C, 32'h1000_0000, "R1 ring7 config after reset");
    expRd(8'h40, 32'h0, "R1 ring0 index after reset");
    push(2, 32'h4, "R10 pause time port after reset");

    // configuration layout: threshold 8, size 8, junk bits dropped
    wrReg(8'h20, 32'h08FF_FE08);
    expRd(8'h20, 32'h0800_0008, "R2 ring0 config fields");

    // reserved word and index masking
    wrReg(8'h44, 32'h0000_00AB);
    expRd(8'h44, 32'h0, "R3 reserved reads zero");
    expRd(8'h40, 32'h0, "R3 reserved write left ring0 index");
    wrReg(8'h48, 32'h0000_01FF);
    expRd(8'h48, 32'hFF, "R3 index masked to 8 bits");
    wrReg(8'h48, 32'h0);

    // ring0 short (free 0 < 8), enable set but flow off
    wrReg(8'h00, 32'h0000_4000);
    tick(2);
    expReq(1'b0, "R6 no request while flow off");
    wrReg(8'h00, 32'h0);

    // flow on with enable clear: reload behind current index
    setFlow(1'b1);
    expRd(8'h40, 32'h7, "R7 ring0 reloaded to size-1");
    expRd(8'h48, 32'h0, "R7 size-0 ring reloaded to zero");
    tick(2);
    expReq(1'b0, "R6 no request while enable clear");

    // threshold 4, then enable: free 7, not short; size-0 rings never short
    wrReg(8'h20, 32'h0400_0008);
    wrReg(8'h00, 32'h0000_4000);
    tick(2);
    expReq(1'b0, "R5 no request with enough free and size-0 rings");
    consume(3'd0, 3);
    tick(2);
    expReq(1'b0, "R5 free equals threshold");
    consume(3'd0, 1);
    expReq(1'b0, "R5 request not yet after causing edge");
    tick(1);
    expReq(1'b1, "R5 request one edge later");

    // hold, then acknowledge and re-arm (pause time 4, H = 2)
    tick(3);
    expReq(1'b1, "R8 held until acknowledge");
    ack();
    expReq(1'b0, "R9 dropped after acknowledge");
    tick(1);
    expReq(1'b0, "R9 re-arm edge 1");
    tick(1);
    expReq(1'b0, "R9 re-arm edge 2");
    tick(1);
    expReq(1'b1, "R9 request again after H+1 edges");

    // returning buffers withdraws the request; modulo free count (cur 4)
    wrReg(8'h40, 32'h7);
    tick(1);
    expReq(1'b1, "R4 free 3 still short");
    wrReg(8'h40, 32'h1);
    expReq(1'b1, "R8 request until next edge");
    tick(1);
    expReq(1'b0, "R4 R8 free (1-4) mod 8 = 5 withdraws");

    // wrap of the current index
    wrReg(8'h40, 32'h3);
    tick(1);
    consume(3'd0, 3);
    tick(1);
    expReq(1'b0, "R4 free 4 at index 7");
    consume(3'd0, 1);
    tick(1);
    expReq(1'b1, "R4 wrap to index 0 gives free 3");

    // flow off drops, flow on reloads behind index 0
    setFlow(1'b0);
    expReq(1'b0, "R6 flow off drops request");
    setFlow(1'b1);
    expRd(8'h40, 32'h7, "R7 reload behind index 0");
    tick(2);
    expReq(1'b0, "R7 ring marked free");

    // pause time width
    wrReg(8'h04, 32'h0001_2345);
    expRd(8'h04, 32'h2345, "R10 pause time register");
    push(2, 32'h2345, "R10 pause time port");

    tick(2);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule